// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a write-only serial slave. It takes a bit clock, a data line and an active-low chip select, and it writes each received word into a small addressed bank of control registers. The register outputs set up a line-locked clock generator and the converter outputs around it: a 12-bit line counter value, a 6-bit fine clock delay, sync polarity, converter output tri-state, six force-low controls for the clock and sync outputs, a sync delay, clock source and input type, counter disable, charge-pump current, oscillator range and divider.

The serial pins are asynchronous to the block clock. A chain of synchronizer flops brings them into the clock domain, and an edge detector finds the rising edges of the bit clock and of chip select. Bits enter while chip select is low. Raising chip select commits the word. Only the last 11 bits of a frame are decoded, so a host may send a 16-bit frame in which the first 5 bits are padding.

Top module: `sercfg_top`

## Requirements
- R1: After reset every control output is zero.
- R2: On each rising edge of `ser_clk` while `ser_csn` is low, one bit of `ser_dat` is taken, most significant bit first. Of the last 11 bits taken, the first 8 are the data byte (bit 7 first) and the last 3 are the address (bit 2 first). The word is written on the rising edge of `ser_csn` and appears on the outputs no later than 10 `clk` cycles after that edge.
- R3: A frame longer than 11 bits is accepted, and its leading extra bits have no effect.
- R4: Address 1 writes `line_count[7:0]` from data[7:0]. Address 2 writes `line_count[11:8]` from data[3:0], and data[7:4] is ignored.
- R5: Address 3 writes `clk_delay` from data[5:0], `hsync_invert` from data[6] and `adc_hiz` from data[7].
- R6: Address 4 writes `force_low` from data[5:0], and `sync_delay` from data[7:6]. The `force_low` bits, from bit 0 up, control: pixel clock, inverted pixel clock, sync, inverted sync, converter clock A, converter clock B.
- R7: Address 5 writes `clk_ext_sel` from data[0], `ext_pecl` from data[1], `count_off` from data[2], `cp_code` from data[4:3], `osc_high` from data[5] and `div_code` from data[7:6].
- R8: A frame addressed to 0, 6 or 7 changes no output.
- R9: No output changes while `ser_csn` is low. No output changes when `ser_clk` toggles while `ser_csn` is high.
- R10: A write to one address leaves the fields of every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_csn | input | 1 | Chip select, active low; a rising edge commits the frame |
| line_count | output | 12 | Line counter value |
| clk_delay | output | 6 | Fine clock delay in 1/32 clock steps |
| hsync_invert | output | 1 | Inverts the polarity of the sync input |
| adc_hiz | output | 1 | Tri-states the converter data outputs |
| force_low | output | 6 | Per-output force-low controls |
| sync_delay | output | 2 | Sync delay of 0 to 3 clocks |
| clk_ext_sel | output | 1 | 1 selects the external clock, 0 selects the oscillator |
| ext_pecl | output | 1 | External clock type: 1 is differential, 0 is CMOS |
| count_off | output | 1 | Disables the line counter |
| cp_code | output | 2 | Charge-pump current code |
| osc_high | output | 1 | Selects the high oscillator range |
| div_code | output | 2 | Divider code (1, 1/2, 1/4, 1/8) |

## Verification
The assertions assume that `ser_dat` is stable around each rising edge of `ser_clk` for longer than the synchronizer delay. They also assume that every level of `ser_clk` and `ser_csn` lasts at least two `clk` cycles, so that the edge detector sees every edge. The bench holds each serial level for four block clocks, changes data only while `ser_clk` is low, and allows a settling gap after each commit. This keeps the stimulus inside those limits.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int CNT_W   = 12;
  localparam int DLY_W   = 6;
  localparam int GATE_N  = 6;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [CNT_W-1:0]  line_count;
    logic [DLY_W-1:0]  clk_delay;
    logic              hsync_invert;
    logic              adc_hiz;
    logic [GATE_N-1:0] force_low;
    logic [1:0]        sync_delay;
    logic              clk_ext_sel;
    logic              ext_pecl;
    logic              count_off;
    logic [1:0]        cp_code;
    logic              osc_high;
    logic [1:0]        div_code;
  } cfg_t;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_TIMING = 3'd3;
  localparam logic [ADDR_W-1:0] A_GATES  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLKGEN = 3'd5;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-1:ADDR_W];
  endfunction

  function automatic logic addr_used(input logic [ADDR_W-1:0] a);
    return (a >= A_CNT_LO) && (a <= A_CLKGEN);
  endfunction

  // Merge one committed word into the current configuration.
  function automatic cfg_t apply_write(input cfg_t cur, input logic [ADDR_W-1:0] a,
                                       input logic [DATA_W-1:0] d);
    cfg_t n;
    n = cur;
    case (a)
      A_CNT_LO: n.line_count[7:0] = d;
      A_CNT_HI: n.line_count[CNT_W-1:8] = d[CNT_W-9:0];
      A_TIMING: begin
        n.clk_delay    = d[DLY_W-1:0];
        n.hsync_invert = d[6];
        n.adc_hiz      = d[7];
      end
      A_GATES: begin
        n.force_low  = d[GATE_N-1:0];
        n.sync_delay = d[7:6];
      end
      A_CLKGEN: begin
        n.clk_ext_sel = d[0];
        n.ext_pecl    = d[1];
        n.count_off   = d[2];
        n.cp_code     = d[4:3];
        n.osc_high    = d[5];
        n.div_code    = d[7:6];
      end
      default: n = cur;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_csn,
  output logic dat_s,
  output logic csn_s,
  output logic sck_rise,
  output logic cs_rise
);
  logic [STAGES-1:0] sck_q, dat_q, csn_q;
  logic sck_prev, csn_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= '0;
      dat_q    <= '0;
      csn_q    <= '1;
      sck_prev <= 1'b0;
      csn_prev <= 1'b1;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], ser_clk};
      dat_q    <= {dat_q[STAGES-2:0], ser_dat};
      csn_q    <= {csn_q[STAGES-2:0], ser_csn};
      sck_prev <= sck_q[STAGES-1];
      csn_prev <= csn_q[STAGES-1];
    end
  end

  assign dat_s    = dat_q[STAGES-1];
  assign csn_s    = csn_q[STAGES-1];
  assign sck_rise = sck_q[STAGES-1] & ~sck_prev;
  assign cs_rise  = csn_q[STAGES-1] & ~csn_prev;

  // R2: a commit strobe lasts exactly one cycle
  p_commit_single_r2: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !cs_rise);
endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift
  import sercfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               dat_s,
  input  logic               csn_s,
  input  logic               sck_rise,
  input  logic               cs_rise,
  output logic [FRAME_W-1:0] word,
  output logic               wr_fire
);
  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (sck_rise && !csn_s) word <= {word[FRAME_W-2:0], dat_s};
  end

  assign wr_fire = cs_rise;

  // R9: bit clock edges seen while deselected leave the word alone
  p_shift_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && csn_s) |=> $stable(word));
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] word,
  input  logic               wr_fire,
  output cfg_t               cfg
);
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_hit;

  assign wr_addr = frame_addr(word);
  assign wr_data = frame_data(word);
  assign wr_hit  = wr_fire && addr_used(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (wr_hit) cfg <= apply_write(cfg, wr_addr, wr_data);
  end

  // R9: the bank only moves in the cycle after a commit
  p_change_needs_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(cfg));
  // R8: unused addresses leave the bank untouched
  p_unused_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !addr_used(wr_addr)) |=> $stable(cfg));
  // R4: the high counter write keeps the low byte
  p_cnt_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && wr_addr == A_CNT_HI) |=> $stable(cfg.line_count[7:0]));
endmodule

// File: rtl/sercfg_top.sv
module sercfg_top
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_csn,
  output logic [CNT_W-1:0]  line_count,
  output logic [DLY_W-1:0]  clk_delay,
  output logic              hsync_invert,
  output logic              adc_hiz,
  output logic [GATE_N-1:0] force_low,
  output logic [1:0]        sync_delay,
  output logic              clk_ext_sel,
  output logic              ext_pecl,
  output logic              count_off,
  output logic [1:0]        cp_code,
  output logic              osc_high,
  output logic [1:0]        div_code
);
  logic dat_s, csn_s, sck_rise, cs_rise, wr_fire;
  logic [FRAME_W-1:0] word;
  cfg_t cfg;

  sercfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_csn(ser_csn),
    .dat_s(dat_s), .csn_s(csn_s), .sck_rise(sck_rise), .cs_rise(cs_rise));

  sercfg_shift u_shift (
    .clk(clk), .rst(rst), .dat_s(dat_s), .csn_s(csn_s), .sck_rise(sck_rise),
    .cs_rise(cs_rise), .word(word), .wr_fire(wr_fire));

  sercfg_regs u_regs (
    .clk(clk), .rst(rst), .word(word), .wr_fire(wr_fire), .cfg(cfg));

  assign line_count   = cfg.line_count;
  assign clk_delay    = cfg.clk_delay;
  assign hsync_invert = cfg.hsync_invert;
  assign adc_hiz      = cfg.adc_hiz;
  assign force_low    = cfg.force_low;
  assign sync_delay   = cfg.sync_delay;
  assign clk_ext_sel  = cfg.clk_ext_sel;
  assign ext_pecl     = cfg.ext_pecl;
  assign count_off    = cfg.count_off;
  assign cp_code      = cfg.cp_code;
  assign osc_high     = cfg.osc_high;
  assign div_code     = cfg.div_code;

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (line_count == '0 && force_low == '0 && clk_delay == '0));
endmodule

// File: tb/sercfg_top_bench.sv
module sercfg_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1;
  logic [11:0] line_count;
  logic [5:0]  clk_delay, force_low;
  logic hsync_invert, adc_hiz, clk_ext_sel, ext_pecl, count_off, osc_high;
  logic [1:0] sync_delay, cp_code, div_code;

  always #2 clk = ~clk;

  sercfg_top u_sercfg_top (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_csn(ser_csn),
    .line_count(line_count), .clk_delay(clk_delay), .hsync_invert(hsync_invert),
    .adc_hiz(adc_hiz), .force_low(force_low), .sync_delay(sync_delay),
    .clk_ext_sel(clk_ext_sel), .ext_pecl(ext_pecl), .count_off(count_off),
    .cp_code(cp_code), .osc_high(osc_high), .div_code(div_code));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_cnt = 0, m_dly = 0, m_inv = 0, m_hiz = 0, m_fl = 0, m_sd = 0;
  int m_src = 0, m_pecl = 0, m_off = 0, m_cp = 0, m_osc = 0, m_div = 0;
  logic [47:0] snap;

  function automatic logic [47:0] all_out();
    return {line_count, clk_delay, hsync_invert, adc_hiz, force_low, sync_delay,
            clk_ext_sel, ext_pecl, count_off, cp_code, osc_high, div_code};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "line_count", int'(line_count), m_cnt);
    check(req, "clk_delay", int'(clk_delay), m_dly);
    check(req, "hsync_invert", int'(hsync_invert), m_inv);
    check(req, "adc_hiz", int'(adc_hiz), m_hiz);
    check(req, "force_low", int'(force_low), m_fl);
    check(req, "sync_delay", int'(sync_delay), m_sd);
    check(req, "clk_ext_sel", int'(clk_ext_sel), m_src);
    check(req, "ext_pecl", int'(ext_pecl), m_pecl);
    check(req, "count_off", int'(count_off), m_off);
    check(req, "cp_code", int'(cp_code), m_cp);
    check(req, "osc_high", int'(osc_high), m_osc);
    check(req, "div_code", int'(div_code), m_div);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shifts n bits of v (top first); snapshot checked just before deselect.
  task automatic send_bits(input logic [31:0] v, input int n);
    ser_csn = 1'b0;
    ticks(4);
    snap = all_out();
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      ticks(4);
      ser_clk = 1'b1;
      ticks(4);
      ser_clk = 1'b0;
    end
    ticks(4);
    check("R9", "outputs held while selected", int'(all_out() != snap), 0);
    ser_csn = 1'b1;
    ticks(10);
  endtask

  task automatic model_write(input int a, input int d);
    case (a)
      1: m_cnt = (m_cnt / 256) * 256 + d;
      2: m_cnt = (d % 16) * 256 + (m_cnt % 256);
      3: begin m_dly = d % 64; m_inv = (d / 64) % 2; m_hiz = d / 128; end
      4: begin m_fl = d % 64; m_sd = d / 64; end
      5: begin
        m_src = d % 2; m_pecl = (d / 2) % 2; m_off = (d / 4) % 2;
        m_cp = (d / 8) % 4; m_osc = (d / 32) % 2; m_div = d / 64;
      end
      default: ;
    endcase
  endtask

  task automatic write_reg(input int a, input int d, input string req);
    send_bits(d * 8 + a, 11);
    model_write(a, d);
    compare_all(req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ticks(5);
    rst = 1'b0;
    ticks(3);
    compare_all("R1");
    write_reg(1, 8'hA5, "R4");
    write_reg(2, 8'hF7, "R4");
    write_reg(3, 8'hC5, "R5");
    write_reg(3, 8'h2A, "R5");
    write_reg(4, 8'h9B, "R6");
    write_reg(4, 8'h64, "R6");
    write_reg(5, 8'hB6, "R7");
    write_reg(5, 8'h49, "R7");
    write_reg(1, 8'h3E, "R10");
    write_reg(0, 8'hFF, "R8");
    write_reg(6, 8'hFF, "R8");
    write_reg(7, 8'h00, "R8");
    // R3: 16-bit frame, five leading padding ones
    send_bits({16'b11111_00111100_010}, 16);
    model_write(2, 8'h3C);
    compare_all("R3");
    // R2: bit order, alternating pattern into the low counter byte
    send_bits({8'h5A, 3'd1}, 11);
    model_write(1, 8'h5A);
    compare_all("R2");
    // R9: bit clock toggling while deselected
    snap = all_out();
    ser_dat = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ser_clk = 1'b1; ticks(4);
      ser_clk = 1'b0; ticks(4);
    end
    ticks(6);
    check("R9", "no change with deselected bit clock", int'(all_out() != snap), 0);
    compare_all("R9");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule